// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Controller

This block moves 8-bit characters over a four-wire synchronous serial link, either as the side that generates the serial clock or as the side that follows it. A small register port sets the role, the bit order and the clock rate. Software starts a transfer by writing a byte into the data register and later reads the received byte back from the same address. Each serial clock period carries one bit out and one bit in at the same time. The clock idles low, input bits are sampled on its rising edge, and output bits change on its falling edge.

The transmit side has a single buffer. A data write while a byte is still shifting is refused and raises a collision flag. The receive side has a holding register that keeps the last completed byte while the next one shifts in. A byte that is not read in time is replaced by the newer one. The clock divider offers four base ratios, and a double-speed bit halves each of them. In the follower role the serial clock, select and data inputs pass through two-flop synchronizers. A high select resets the bit position so that framing realigns.

Top module: `spi_xcvr`

## Requirements
- R1: Register map on `reg_addr`. Address 0 is control: bit 0 selects the clock-driving role (1) or the follower role (0), bit 1 selects LSB-first (1) or MSB-first (0), bits 3:2 are the rate code, and bit 4 is double speed. Address 1 is status (read only): bit 7 is end-of-transfer, bit 6 is write collision, bit 0 is busy. Address 2 is data: a write loads the transmit shifter and a read returns the receive holding register. After reset all registers read 0, `ss_n_o` is 1 and `sck_o` is 0.
- R2: In the clock-driving role the `sck_o` period in system clocks is 4, 16, 64 or 128 for rate codes 0 to 3, and half of that when the double-speed bit is 1.
- R3: In the clock-driving role a data write while idle sends that byte on `mosi_o` with exactly 8 rising `sck_o` edges. The 8 bits sampled from `miso_i` on those rising edges form the received byte.
- R4: The bit order set in control applies to both directions. MSB-first sends and receives bit 7 first; LSB-first sends and receives bit 0 first.
- R5: In the clock-driving role `ss_n_o` is low for the whole transfer and high when idle, and `sck_o` is low whenever `ss_n_o` is high.
- R6: In the follower role, with `ss_n_i` low, the block samples `mosi_i` on rising `sck_i` edges and drives its loaded byte on `miso_o` in the same exchange. `miso_oe` is 1 only in the follower role while the synchronized select is low.
- R7: In the follower role a high `ss_n_i` resets the bit position and `sck_i` edges are ignored. A partial byte is discarded and the next byte after select falls again is framed from its first bit.
- R8: A data write while busy leaves the byte in progress unchanged and sets the collision flag. The next data write made while not busy clears it.
- R9: If the holding register is not read before the next byte completes, it is overwritten with the newer byte.
- R10: End-of-transfer sets when the eighth bit of a byte is sampled. It clears when a status read that shows it set is followed by a data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sck_o | output | 1 | Serial clock driven in the clock-driving role |
| mosi_o | output | 1 | Serial data out in the clock-driving role |
| ss_n_o | output | 1 | Select driven in the clock-driving role, active low |
| miso_i | input | 1 | Serial data in for the clock-driving role |
| sck_i | input | 1 | Serial clock received in the follower role |
| mosi_i | input | 1 | Serial data in for the follower role |
| ss_n_i | input | 1 | Select received in the follower role, active low |
| miso_o | output | 1 | Serial data out for the follower role |
| miso_oe | output | 1 | Output enable for `miso_o` |

## Verification
The checks assume the follower-side clock is no faster than a quarter of the system clock. They also assume `mosi_i` changes only around falling `sck_i` edges, so that the synchronized samples stay aligned with the clock. The stimulus plays the remote clock-driving side with a half period of six system clocks and changes data only while the clock is low. In the clock-driving role a behavioural remote side updates `miso_i` on falling `sck_o` edges. Control is changed only while the block is idle, because the assertions on framing do not cover a role change in the middle of a byte.

// File: rtl/spi_xcvr.sv
module spi_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         sck_o,
  output logic         mosi_o,
  output logic         ss_n_o,
  input  logic         miso_i,
  input  logic         sck_i,
  input  logic         mosi_i,
  input  logic         ss_n_i,
  output logic         miso_o,
  output logic         miso_oe
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic mst, lsbf, dbl;
  logic [1:0] rate;
  logic [W-1:0] sh, rxh, shin;
  logic rbit, done, col, armed, act, sck_r;
  logic [CW-1:0] cnt;
  logic [6:0] dc, half, base;
  logic [1:0] sck_q, ss_q, mosi_q;
  logic sck_d, ss_s, in_bit, rise, fall, busy, tick, wr_data, shout;

  always_comb
    case (rate)
      2'd0:    base = 7'd2;
      2'd1:    base = 7'd8;
      2'd2:    base = 7'd32;
      default: base = 7'd64;
    endcase

  assign half    = dbl ? (base >> 1) : base;
  assign ss_s    = ss_q[1];
  assign tick    = act && (dc == half - 7'd1);
  assign rise    = mst ? (tick && !sck_r) : (!ss_s && sck_q[1] && !sck_d);
  assign fall    = mst ? (tick && sck_r)  : (!ss_s && !sck_q[1] && sck_d);
  assign in_bit  = mst ? miso_i : mosi_q[1];
  assign busy    = mst ? act : (cnt != '0);
  assign wr_data = reg_wr && reg_addr == 2'd2;
  assign shin    = lsbf ? {in_bit, sh[W-1:1]} : {sh[W-2:0], in_bit};
  assign shout   = lsbf ? sh[0] : sh[W-1];

  assign sck_o   = sck_r;
  assign ss_n_o  = !act;
  assign mosi_o  = shout;
  assign miso_o  = shout;
  assign miso_oe = !mst && !ss_s;

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {{(W-5){1'b0}}, dbl, rate, lsbf, mst};
      2'd1:    reg_rdata = {done, col, {(W-3){1'b0}}, busy};
      2'd2:    reg_rdata = rxh;
      default: reg_rdata = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; ss_q <= '1; mosi_q <= '0; sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[0], sck_i};
      ss_q <= {ss_q[0], ss_n_i};
      mosi_q <= {mosi_q[0], mosi_i};
      sck_d <= sck_q[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mst <= 1'b0; lsbf <= 1'b0; dbl <= 1'b0; rate <= '0;
    end else if (reg_wr && reg_addr == 2'd0) begin
      mst <= reg_wdata[0]; lsbf <= reg_wdata[1];
      rate <= reg_wdata[3:2]; dbl <= reg_wdata[4];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act <= 1'b0; sck_r <= 1'b0; dc <= '0;
    end else if (wr_data && mst && !act) begin
      act <= 1'b1; sck_r <= 1'b0; dc <= '0;
    end else if (act) begin
      if (tick) begin
        dc <= '0;
        sck_r <= !sck_r;
        if (sck_r && cnt == '0) act <= 1'b0;
      end else dc <= dc + 7'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; rxh <= '0; rbit <= 1'b0; cnt <= '0;
      done <= 1'b0; col <= 1'b0; armed <= 1'b0;
    end else begin
      if (wr_data) col <= busy;
      if (wr_data && !busy) sh <= reg_wdata;
      else if (fall && cnt != '0) sh <= lsbf ? {rbit, sh[W-1:1]} : {sh[W-2:0], rbit};
      if (reg_rd && reg_addr == 2'd1 && done) armed <= 1'b1;
      if (reg_rd && reg_addr == 2'd2 && armed) begin
        done <= 1'b0; armed <= 1'b0;
      end
      if (!mst && ss_s) cnt <= '0;
      else if (rise) begin
        rbit <= in_bit;
        if (cnt == LAST) begin
          cnt <= '0; rxh <= shin; done <= 1'b1;
        end else cnt <= cnt + 1'b1;
      end
    end
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
  parameter int W = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic          sck_o,
  input logic          ss_n_o,
  input logic          miso_oe,
  input logic          mst,
  input logic          busy,
  input logic          col,
  input logic          done,
  input logic          rise,
  input logic          fall,
  input logic          ss_s,
  input logic [W-1:0]  sh,
  input logic [W-1:0]  rxh,
  input logic [CW-1:0] cnt
);
  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_o |-> !sck_o);
  p_oe_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mst |-> !miso_oe);
  p_realign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst && ss_s) |=> cnt == '0);
  p_col_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && busy) |=> col);
  p_shift_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && busy && !fall) |=> $stable(sh));
  p_rx_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rxh) |-> done);
  p_done_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cnt == CW'(W - 1)) |=> done);
endmodule

bind spi_xcvr spi_xcvr_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .sck_o(sck_o), .ss_n_o(ss_n_o), .miso_oe(miso_oe), .mst(mst),
  .busy(busy), .col(col), .done(done), .rise(rise), .fall(fall),
  .ss_s(ss_s), .sh(sh), .rxh(rxh), .cnt(cnt)
);

// File: tb/sim_spi_xcvr.sv
module sim_spi_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic sck_o, mosi_o, ss_n_o, miso_o, miso_oe;
  logic miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  int checks = 0, fails = 0;

  logic [7:0] pat = '0, cap = '0;
  logic lsb = 1'b0;
  int k = 0, nrise = 0;
  time t1 = 0, t2 = 0;

  spi_xcvr u0 (.*);

  always #5 clk = !clk;

  always @(negedge ss_n_o) begin
    k = 0;
    miso_i = lsb ? pat[0] : pat[7];
  end
  always @(negedge sck_o) if (!ss_n_o) begin
    k = k + 1;
    if (k < 8) miso_i = lsb ? pat[k] : pat[7-k];
  end
  always @(posedge sck_o) begin
    cap = {cap[6:0], mosi_o};
    nrise = nrise + 1;
    if (nrise == 1) t1 = $time;
    if (nrise == 2) t2 = $time;
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !ss_n_o; i++) @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] mo, input logic o, output logic [7:0] so);
    for (int i = 0; i < 8; i++) begin
      mosi_i = o ? mo[i] : mo[7-i];
      repeat (6) @(negedge clk);
      if (o) so[i] = miso_o; else so[7-i] = miso_o;
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, so, tx;
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", ss_n_o === 1'b1 && sck_o === 1'b0, {ss_n_o, sck_o}, 2);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      chk("R1 reset register", v === 8'h00, v, 0);
    end

    for (int r = 0; r < 4; r++)
      for (int db = 0; db < 2; db++)
        for (int o = 0; o < 2; o++) begin
          wr(2'd0, 8'((db << 4) | (r << 2) | (o << 1) | 1));
          rd(2'd0, v);
          chk("R1 control readback", v == 8'((db << 4) | (r << 2) | (o << 1) | 1), v, 0);
          tx = 8'h5A ^ 8'(r * 37 + db * 11 + o * 100);
          pat = ~{tx[3:0], tx[7:4]} ^ 8'h21;
          lsb = o[0];
          nrise = 0;
          wr(2'd2, tx);
          chk("R5 select low during transfer", ss_n_o === 1'b0, ss_n_o, 0);
          wait_idle();
          d = (4 << (2 * r)) >> db;
          if (r == 3) d = 128 >> db;
          chk("R2 sck period", (t2 - t1) == d * 10, int'((t2 - t1) / 10), d);
          chk("R3 rising edge count", nrise == 8, nrise, 8);
          chk("R4 mosi bit order", cap == (o ? rev8(tx) : tx), cap, o ? rev8(tx) : tx);
          chk("R5 sck idle low", sck_o === 1'b0 && ss_n_o === 1'b1, sck_o, 0);
          rd(2'd1, v);
          chk("R10 done set", v[7] == 1'b1 && v[0] == 1'b0, v, 8'h80);
          rd(2'd2, v);
          chk("R3 received byte", v == pat, v, pat);
          rd(2'd1, v);
          chk("R10 done cleared", v[7] == 1'b0, v, 0);
        end

    wr(2'd0, 8'h11);
    lsb = 1'b0; pat = 8'h00; nrise = 0;
    wr(2'd2, 8'h3C);
    repeat (2) @(negedge clk);
    wr(2'd2, 8'hFF);
    rd(2'd1, v);
    chk("R8 collision flag set", v[6] == 1'b1, v, 8'h41);
    wait_idle();
    chk("R8 shift unaffected", cap == 8'h3C, cap, 8'h3C);
    wr(2'd2, 8'h81);
    rd(2'd1, v);
    chk("R8 collision cleared", v[6] == 1'b0, v, 0);
    wait_idle();

    for (int o = 0; o < 2; o++) begin
      wr(2'd0, 8'(o << 1));
      tx = o ? 8'hC3 : 8'h96;
      wr(2'd2, tx);
      chk("R6 oe low while deselected", miso_oe === 1'b0, miso_oe, 0);
      ss_n_i = 1'b0;
      repeat (4) @(negedge clk);
      chk("R6 oe high while selected", miso_oe === 1'b1, miso_oe, 1);
      sbyte(8'h4B ^ 8'(o), o[0], so);
      chk("R6 follower sent byte", so == tx, so, tx);
      rd(2'd1, v);
      rd(2'd2, v);
      chk("R6 follower received byte", v == (8'h4B ^ 8'(o)), v, 8'h4B ^ 8'(o));
      rd(2'd1, v);
      chk("R10 follower done cleared", v[7] == 1'b0, v, 0);

      sbyte(8'h11, o[0], so);
      sbyte(8'hE7, o[0], so);
      rd(2'd2, v);
      chk("R9 overrun keeps newest", v == 8'hE7, v, 8'hE7);

      for (int i = 0; i < 3; i++) begin
        mosi_i = 1'b1;
        repeat (6) @(negedge clk); sck_i = 1'b1;
        repeat (6) @(negedge clk); sck_i = 1'b0;
      end
      ss_n_i = 1'b1;
      repeat (6) @(negedge clk);
      rd(2'd1, v);
      chk("R7 bit position reset", v[0] == 1'b0, v, 0);
      for (int i = 0; i < 4; i++) begin
        repeat (6) @(negedge clk); sck_i = 1'b1;
        repeat (6) @(negedge clk); sck_i = 1'b0;
      end
      repeat (6) @(negedge clk);
      rd(2'd1, v);
      chk("R7 edges ignored deselected", v[0] == 1'b0, v, 0);
      rd(2'd2, v);
      chk("R7 holding unchanged", v == 8'hE7, v, 8'hE7);
      ss_n_i = 1'b0;
      repeat (4) @(negedge clk);
      sbyte(8'h2D, o[0], so);
      rd(2'd2, v);
      chk("R7 realigned byte", v == 8'h2D, v, 8'h2D);
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule